// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer with DMA Request

This block is a down-counting interval timer. Its time base is the system clock, first divided by an 8-bit prescaler (divide by value+1) and then by a selectable power-of-two divider. A buffer register holds the reload count. Software moves the buffer into the live counter only by writing the control register with the manual-update bit set. It then starts the timer with a second control write that has the manual-update bit clear. On every underflow the counter either reloads from the buffer and keeps running (auto-reload) or stops at zero (one-shot).

Each underflow is steered to one of two places by a configuration bit. With the bit clear, it raises a one-cycle interrupt pulse. With the bit set, it raises a DMA request that stays high until the DMA engine acknowledges it, and no interrupt is raised. The live count is brought out on a port so the system can observe it. A write of zero to the control register halts the timer. Software uses the block as a periodic trigger, for example to pace DMA transfers of converter samples at a fixed rate.

Top module: `tmr_dma_timer`

## Requirements
- R1: After synchronous reset every register reads 0, `count_o` is 0, and `irq_o` and `dma_req_o` are low.
- R2: Registers are selected by `addr_i`. 0 is the prescaler, in bits [7:0]. 1 is the configuration: divider select in bits [1:0] and DMA steering in bit 20. 2 is the count buffer, in bits [15:0]. 3 is the control register: start in bit 0, manual update in bit 1, auto-reload in bit 3. Unimplemented bits read 0.
- R3: Divider select codes 0, 1, 2 and 3 divide the prescaled clock by 2, 4, 8 and 16. One tick lasts (prescaler+1)*divisor clock cycles.
- R4: A control write with bit 1 set loads `count_o` from the buffer at that clock edge. While bit 1 stays set the count does not move, even with bit 0 set.
- R5: After a control write with bit 0 set and bit 1 clear, the first underflow occurs at the clock edge (buffer+1)*tick cycles later. The prescaler and divider restart at every control write.
- R6: With bit 3 set, an underflow reloads the count from the buffer and the next underflow follows after the same interval. With bit 3 clear, the count stays at 0 and no further underflow occurs until the control register is written again.
- R7: With configuration bit 20 clear, each underflow makes `irq_o` high for exactly the one cycle after the underflow edge, and `dma_req_o` stays low.
- R8: With configuration bit 20 set, an underflow sets `dma_req_o`. The request stays high until `dma_ack_i` is sampled high, and the edge that samples it clears the request. `irq_o` stays low.
- R9: When an acknowledge and a new underflow fall on the same clock edge in DMA mode, `dma_req_o` stays high.
- R10: Writing 0 to the control register stops the timer: `count_o` holds its value and no events are raised.
- R11: Writing the buffer while the timer runs does not change the running count. The new value takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` (combinational) |
| dma_ack_i | input | 1 | DMA acknowledge; clears a pending request |
| irq_o | output | 1 | Underflow interrupt pulse |
| dma_req_o | output | 1 | Held DMA request on underflow |
| count_o | output | 16 | Live counter value |

## Verification
In DMA mode, a new underflow and an acknowledge of the previous request can land on the same clock edge. The request must then survive. To provoke this, the bench runs the shortest period (prescaler 0, divide by 2, buffer 0), so underflows arrive every second cycle. It holds `dma_ack_i` high across one underflow edge and the non-underflow edge after it. It then expects `dma_req_o` to be high after the first of these edges and low after the second.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DSEL_W = 2;
    localparam int DIVC_W = 2 ** DSEL_W;

    localparam logic [1:0] ADDR_PRE = 2'd0;
    localparam logic [1:0] ADDR_CFG = 2'd1;
    localparam logic [1:0] ADDR_BUF = 2'd2;
    localparam logic [1:0] ADDR_CTL = 2'd3;

    localparam int CFG_DMA_BIT    = 20;
    localparam int CTL_START_BIT  = 0;
    localparam int CTL_MAN_BIT    = 1;
    localparam int CTL_RELOAD_BIT = 3;

    typedef struct packed {
        logic              dma_sel;
        logic [DSEL_W-1:0] dsel;
    } cfg_t;

    typedef struct packed {
        logic reload;
        logic manual;
        logic start;
    } ctrl_t;

    typedef enum logic {
        ROUTE_IRQ = 1'b0,
        ROUTE_DMA = 1'b1
    } route_t;

    function automatic logic [DIVC_W-1:0] div_last(input logic [DSEL_W-1:0] s);
        return DIVC_W'((2 << s) - 1);
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [PRE_W-1:0] presc_o,
    output cfg_t             cfg_o,
    output logic [CNT_W-1:0] buf_o,
    output ctrl_t            ctrl_o,
    output logic             ctl_wr_o,
    output logic             ctl_load_o,
    output logic [31:0]      rdata_o
);

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    assign ctl_wr_o   = wr_en_i && (addr_i == ADDR_CTL);
    assign ctl_load_o = ctl_wr_o && wdata_i[CTL_MAN_BIT];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            presc_o <= '0;
            cfg_o   <= '0;
            buf_o   <= '0;
            ctrl_o  <= '0;
        end else if (wr_en_i) begin
            case (addr_i)
                ADDR_PRE: presc_o <= wdata_i[PRE_W-1:0];
                ADDR_CFG: begin
                    cfg_o.dma_sel <= wdata_i[CFG_DMA_BIT];
                    cfg_o.dsel    <= wdata_i[DSEL_W-1:0];
                end
                ADDR_BUF: buf_o <= wdata_i[CNT_W-1:0];
                default: begin
                    ctrl_o.reload <= wdata_i[CTL_RELOAD_BIT];
                    ctrl_o.manual <= wdata_i[CTL_MAN_BIT];
                    ctrl_o.start  <= wdata_i[CTL_START_BIT];
                end
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_PRE: rdata_o[PRE_W-1:0] = presc_o;
            ADDR_CFG: begin
                rdata_o[CFG_DMA_BIT]  = cfg_o.dma_sel;
                rdata_o[DSEL_W-1:0]   = cfg_o.dsel;
            end
            ADDR_BUF: rdata_o[CNT_W-1:0] = buf_o;
            default: begin
                rdata_o[CTL_RELOAD_BIT] = ctrl_o.reload;
                rdata_o[CTL_MAN_BIT]    = ctrl_o.manual;
                rdata_o[CTL_START_BIT]  = ctrl_o.start;
            end
        endcase
    end

endmodule

// File: rtl/tmr_clkdiv.sv
module tmr_clkdiv
    import tmr_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [PRE_W-1:0]  presc_i,
    input  logic [DSEL_W-1:0] dsel_i,
    output logic              tick_o
);

    logic [PRE_W-1:0]  pcnt;
    logic [DIVC_W-1:0] dcnt;
    logic [DIVC_W-1:0] dlast;
    logic              ptick;

    assign dlast  = div_last(dsel_i);
    assign ptick  = run_i && (pcnt == presc_i);
    assign tick_o = ptick && (dcnt == dlast);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i || !run_i) begin
            pcnt <= '0;
            dcnt <= '0;
        end else if (ptick) begin
            pcnt <= '0;
            dcnt <= (dcnt == dlast) ? '0 : dcnt + DIVC_W'(1);
        end else begin
            pcnt <= pcnt + PRE_W'(1);
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ctl_wr_i,
    input  logic             ctl_load_i,
    input  logic             tick_i,
    input  logic             reload_en_i,
    input  logic [CNT_W-1:0] buf_i,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             uflow_o
);

    assign uflow_o = tick_i && !ctl_wr_i && (count_o == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_o <= '0;
            done_o  <= 1'b0;
        end else if (ctl_wr_i) begin
            done_o <= 1'b0;
            if (ctl_load_i) begin
                count_o <= buf_i;
            end
        end else if (uflow_o) begin
            if (reload_en_i) begin
                count_o <= buf_i;
            end else begin
                done_o <= 1'b1;
            end
        end else if (tick_i) begin
            count_o <= count_o - CNT_W'(1);
        end
    end

endmodule

// File: rtl/tmr_event.sv
module tmr_event
    import tmr_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   uflow_i,
    input  route_t route_i,
    input  logic   dma_ack_i,
    output logic   irq_o,
    output logic   dma_req_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_o     <= 1'b0;
            dma_req_o <= 1'b0;
        end else begin
            irq_o <= uflow_i && (route_i == ROUTE_IRQ);
            if (uflow_i && (route_i == ROUTE_DMA)) begin
                dma_req_o <= 1'b1;
            end else if (dma_ack_i) begin
                dma_req_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_dma_timer.sv
module tmr_dma_timer
    import tmr_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    input  logic             dma_ack_i,
    output logic             irq_o,
    output logic             dma_req_o,
    output logic [CNT_W-1:0] count_o
);

    logic [PRE_W-1:0] presc_q;
    cfg_t             cfg_q;
    logic [CNT_W-1:0] buf_q;
    ctrl_t            ctrl_q;
    logic             ctl_wr;
    logic             ctl_load;
    logic             tick;
    logic             done;
    logic             uflow;
    logic             run;
    logic             dma_sel;
    route_t           route;

    assign run     = ctrl_q.start && !ctrl_q.manual && !done;
    assign dma_sel = cfg_q.dma_sel;
    assign route   = dma_sel ? ROUTE_DMA : ROUTE_IRQ;

    tmr_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .presc_o    (presc_q),
        .cfg_o      (cfg_q),
        .buf_o      (buf_q),
        .ctrl_o     (ctrl_q),
        .ctl_wr_o   (ctl_wr),
        .ctl_load_o (ctl_load),
        .rdata_o    (rdata_o)
    );

    tmr_clkdiv #(.PRE_W(PRE_W)) u_div (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (run),
        .restart_i (ctl_wr),
        .presc_i   (presc_q),
        .dsel_i    (cfg_q.dsel),
        .tick_o    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .ctl_wr_i    (ctl_wr),
        .ctl_load_i  (ctl_load),
        .tick_i      (tick),
        .reload_en_i (ctrl_q.reload),
        .buf_i       (buf_q),
        .count_o     (count_o),
        .done_o      (done),
        .uflow_o     (uflow)
    );

    tmr_event u_evt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .uflow_i   (uflow),
        .route_i   (route),
        .dma_ack_i (dma_ack_i),
        .irq_o     (irq_o),
        .dma_req_o (dma_req_o)
    );

endmodule

// File: rtl/tmr_dma_timer_chk.sv
module tmr_dma_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_o,
    input logic             dma_req_o,
    input logic             dma_ack_i,
    input logic             dma_sel,
    input logic [CNT_W-1:0] buf_q,
    input logic             run,
    input logic             ctl_wr
);

    a_r1_reset_clear: assert property (@(posedge clk_i)
        rst_i |=> (count_o == '0) && !irq_o && !dma_req_o);

    a_r7_irq_single: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |=> !irq_o);

    a_r8_no_irq_in_dma: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> !$past(dma_sel));

    a_r8_req_held: assert property (@(posedge clk_i) disable iff (rst_i)
        (dma_req_o && !dma_ack_i) |=> dma_req_o);

    a_r4_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (count_o != $past(count_o)) |->
            ((count_o == $past(count_o) - CNT_W'(1)) || (count_o == $past(buf_q))));

    a_r10_hold_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(run) && !$past(ctl_wr)) |-> (count_o == $past(count_o)));

endmodule

bind tmr_dma_timer tmr_dma_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .count_o   (count_o),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o),
    .dma_ack_i (dma_ack_i),
    .dma_sel   (dma_sel),
    .buf_q     (buf_q),
    .run       (run),
    .ctl_wr    (ctl_wr)
);

// File: tb/sim_tmr_dma_timer.sv
`timescale 1ns/1ps
module sim_tmr_dma_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        dma_ack;
    logic        irq;
    logic        dma_req;
    logic [15:0] count;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_dma_timer u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .dma_ack_i (dma_ack),
        .irq_o     (irq),
        .dma_req_o (dma_req),
        .count_o   (count)
    );

    typedef struct packed {
        logic [7:0]  pre;
        logic [1:0]  dsel;
        logic [15:0] n;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{8'd0, 2'd0, 16'd3},
        '{8'd2, 2'd1, 16'd1},
        '{8'd0, 2'd3, 16'd2},
        '{8'd1, 2'd2, 16'd0},
        '{8'd3, 2'd0, 16'd4},
        '{8'd0, 2'd0, 16'd0}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_irq(input int t0, output int d);
        while (!irq && (cyc - t0) < 4000) @(negedge clk);
        d = cyc - t0;
    endtask

    task automatic wait_irq_next(output int d);
        int t0;
        t0 = cyc;
        @(negedge clk);
        wait_irq(t0, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int d, t0, k;
        logic [15:0] held;
        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; dma_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            chk(r == 0, "R1 register reset", r, 0);
        end
        chk(count == 0, "R1 count reset", count, 0);
        chk(!irq && !dma_req, "R1 events low", {irq, dma_req}, 0);

        // R2 readback and field masking
        wr(2'd0, 32'hFFFF_FFA5); rd(2'd0, r); chk(r == 32'hA5, "R2 prescaler", r, 32'hA5);
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, r); chk(r == 32'h0010_0003, "R2 config", r, 32'h0010_0003);
        wr(2'd2, 32'h1234_5678); rd(2'd2, r); chk(r == 32'h5678, "R2 buffer", r, 32'h5678);
        wr(2'd3, 32'h0000_00FF); rd(2'd3, r); chk(r == 32'h0B, "R2 control", r, 32'h0B);
        wr(2'd3, 0);

        // Vector table: R3 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            k = (int'(VEC[i].n) + 1) * (int'(VEC[i].pre) + 1) * (2 << VEC[i].dsel);
            wr(2'd3, 0);
            wr(2'd0, {24'd0, VEC[i].pre});
            wr(2'd1, {30'd0, VEC[i].dsel});
            wr(2'd2, {16'd0, VEC[i].n});
            wr(2'd3, 32'hA);
            chk(count == VEC[i].n, "R4 manual load", count, VEC[i].n);
            wr(2'd3, 32'h9);
            t0 = cyc;
            wait_irq(t0, d);
            chk(d == k, "R5 R3 first underflow", d, k);
            chk(!dma_req, "R7 no request in irq mode", dma_req, 0);
            wait_irq_next(d);
            chk(d == k, "R6 auto-reload period", d, k);
        end
        wr(2'd3, 0);

        // R4 hold while manual update set
        wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 5);
        wr(2'd3, 32'hB);
        repeat (20) @(negedge clk);
        chk(count == 5, "R4 hold with manual bit", count, 5);
        chk(!irq, "R4 no event while held", irq, 0);

        // R6 one-shot
        wr(2'd2, 2);
        wr(2'd3, 32'h2);
        wr(2'd3, 32'h1);
        t0 = cyc;
        wait_irq(t0, d);
        chk(d == 6, "R6 one-shot underflow", d, 6);
        k = 0;
        repeat (30) begin @(negedge clk); if (irq) k++; end
        chk(k == 0, "R6 no second underflow", k, 0);
        chk(count == 0, "R6 one-shot stays zero", count, 0);

        // R10 stop
        wr(2'd2, 9);
        wr(2'd3, 32'hA);
        wr(2'd3, 32'h9);
        repeat (7) @(negedge clk);
        wr(2'd3, 0);
        held = count;
        k = 0;
        repeat (40) begin @(negedge clk); if (irq) k++; end
        chk(count == held, "R10 count held after stop", count, held);
        chk(k == 0, "R10 no events after stop", k, 0);

        // R11 buffer write while running
        wr(2'd2, 3);
        wr(2'd3, 32'hA);
        wr(2'd3, 32'h9);
        t0 = cyc;
        wr(2'd2, 1);
        wait_irq(t0, d);
        chk(d == 8, "R11 running count unaffected", d, 8);
        wait_irq_next(d);
        chk(d == 4, "R11 new buffer at reload", d, 4);
        wr(2'd3, 0);

        // R8 R9 DMA steering
        wr(2'd1, 32'h0010_0000);
        wr(2'd2, 0);
        wr(2'd3, 32'hA);
        wr(2'd3, 32'h9);
        t0 = cyc;
        while (!dma_req && (cyc - t0) < 100) @(negedge clk);
        d = cyc - t0;
        chk(d == 2, "R8 request after underflow", d, 2);
        chk(!irq, "R8 no irq in dma mode", irq, 0);
        repeat (5) @(negedge clk);
        chk(dma_req, "R8 request held without ack", dma_req, 1);
        chk(!irq, "R8 no irq while held", irq, 0);
        dma_ack = 1'b1;
        @(negedge clk);
        chk(dma_req, "R9 ack with underflow keeps request", dma_req, 1);
        @(negedge clk);
        chk(!dma_req, "R8 ack clears request", dma_req, 0);
        dma_ack = 1'b0;
        @(negedge clk);
        chk(dma_req, "R8 next underflow sets request", dma_req, 1);
        wr(2'd3, 0);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        chk(!dma_req, "R10 request cleared after stop", dma_req, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule